// File: doc/BRIEF.md
# Cascaded Serial Codec Control Port

This block is the serial control logic for one channel of a codec chain. Channels are wired in a daisy chain, and the output frame sync of each channel drives the input frame sync of the next. Every word is 16 bits. A frame sync pulse lasts one clock, and the 16 data bits follow it, most significant bit first. Depending on the mode held in register 0, an incoming word is either DAC data or a control word.

A control word carries a 3-bit hop address. A channel that sees a nonzero hop address lowers it by one and sends the word on. A channel that sees zero owns the word. It either writes one of eight local 8-bit registers, or it answers with a reply word that carries the register contents. The reply leaves with its hop address already lowered, so each later channel lowers it again. DAC words are counted, and the DAC output latches only on the word that brings the count up to the programmed number of devices. A sample event sends the channel's own ADC word out on the same serial output. A small arbiter orders this ADC word against relayed words.

Top module: `ccp_top`

## Requirements
- R1: Input framing: a one-clock `sdi_fs` pulse is followed by 16 bits on `sdi`, most significant bit first. Output framing is the same: a one-clock `sdo_fs` pulse is followed by 16 bits on `sdo`, and `sdo_fs` is never high on two cycles in a row.
- R2: When register 0 has bit 5 (mixed) and bit 4 (program) both set, bit 15 of a word selects its type: 1 is a control word and 0 is DAC data.
- R3: A control word has bit 14 for read, bits 13:11 for the hop address, bits 10:8 for the register index and bits 7:0 for data. If the hop address is nonzero, the word is sent out with the hop address lowered by one modulo 8 and all other bits unchanged.
- R4: A control word with hop address 0 and bit 14 clear writes bits 7:0 into register bits 10:8 and sends nothing.
- R5: A control word with hop address 0 and bit 14 set sends the reply {1, 1, 111b, index, register contents}.
- R6: Register 0 holds the device count in bits 2:0 (0 means 8), the program bit in bit 4 and the mixed bit in bit 5. It resets to 0x11. Registers 1 to 7 reset to 0.
- R7: A DAC word raises the DAC frame counter. The word that brings the count up to the device count is copied to `dac_word` with a one-cycle `dac_strobe`, and the counter then clears. Earlier words leave `dac_word` unchanged, and no DAC word is ever sent out.
- R8: With a device count of 1, every DAC word latches at once.
- R9: Program bit 1 with mixed bit 0 makes every word a control word, whatever bit 15 is. Program bit 0 makes every word DAC data.
- R10: A `sample_evt` pulse sends `adc_word`, as captured in that cycle, out as a framed word.
- R11: If an ADC word and a relayed word are both pending, the ADC word goes first. The relayed word follows right after, and neither is lost.
- R12: After reset, `sdo_fs`, `dac_strobe` and `dac_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdi | input | 1 | Serial data in |
| sdi_fs | input | 1 | Input frame sync |
| sample_evt | input | 1 | Sample event, one clock |
| adc_word | input | 16 | ADC word to send on a sample event |
| sdo | output | 1 | Serial data out |
| sdo_fs | output | 1 | Output frame sync |
| dac_word | output | 16 | Latched DAC word |
| dac_strobe | output | 1 | One-cycle pulse when `dac_word` updates |

## Verification
A relayed control word and a sample event can become pending in the same cycle. This happens when `sample_evt` is raised in the cycle right after the last bit of a non-owned control word. The bench provokes this case on purpose. Its scoreboard then expects the ADC word first and the lowered-address relay word second, decoding both from the frames on `sdo`. A wrong priority, or a lost word, shows up as a mismatch or as an item left in the queue.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int WORD_W  = 16;
  localparam int HOP_W   = 3;
  localparam int IDX_W   = 3;
  localparam int RDATA_W = 8;
  localparam int NREGS   = 1 << IDX_W;

  // register 0 field positions
  localparam int CNT_LSB  = 0;
  localparam int PGM_BIT  = 4;
  localparam int MIX_BIT  = 5;
  localparam logic [RDATA_W-1:0] MODE_RST = 8'h11;

  typedef struct packed {
    logic               ctl;
    logic               rd;
    logic [HOP_W-1:0]   hop;
    logic [IDX_W-1:0]   idx;
    logic [RDATA_W-1:0] data;
  } cword_t;

  function automatic cword_t hop_down(cword_t w);
    cword_t r;
    r     = w;
    r.hop = w.hop - HOP_W'(1);
    return r;
  endfunction

  function automatic cword_t make_reply(cword_t req, logic [RDATA_W-1:0] val);
    cword_t r;
    r.ctl  = 1'b1;
    r.rd   = 1'b1;
    r.hop  = req.hop - HOP_W'(1);
    r.idx  = req.idx;
    r.data = val;
    return r;
  endfunction

  function automatic logic [HOP_W:0] dev_total(logic [HOP_W-1:0] f);
    return (f == '0) ? (HOP_W+1)'(1 << HOP_W) : {1'b0, f};
  endfunction
endpackage

// File: rtl/ccp_rx.sv
module ccp_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  input  logic         fs,
  output logic         valid,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] left;
  logic [W-1:0]  sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left  <= '0;
      sh    <= '0;
      valid <= 1'b0;
      word  <= '0;
    end else begin
      valid <= 1'b0;
      if (fs) begin
        left <= CW'(W);
      end else if (left != '0) begin
        sh   <= {sh[W-2:0], sdi};
        left <= left - CW'(1);
        if (left == CW'(1)) begin
          valid <= 1'b1;
          word  <= {sh[W-2:0], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/ccp_ctl.sv
module ccp_ctl
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              rel_req,
  output logic [WORD_W-1:0] rel_word,
  output logic              dac_hit,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_strobe
);
  logic [RDATA_W-1:0] regs [NREGS];
  cword_t             w;
  logic               pgm, mix, is_ctl, mine;
  logic               dac_evt, wr_evt, rd_evt, fwd_evt;
  logic [HOP_W:0]     dac_cnt, total;

  assign w       = cword_t'(in_word);
  assign pgm     = regs[0][PGM_BIT];
  assign mix     = regs[0][MIX_BIT];
  assign is_ctl  = pgm & (~mix | w.ctl);
  assign mine    = (w.hop == '0);
  assign dac_evt = in_valid & ~is_ctl;
  assign wr_evt  = in_valid & is_ctl & mine & ~w.rd;
  assign rd_evt  = in_valid & is_ctl & mine & w.rd;
  assign fwd_evt = in_valid & is_ctl & ~mine;
  assign total   = dev_total(regs[0][CNT_LSB +: HOP_W]);
  assign dac_hit = dac_evt & ((dac_cnt + (HOP_W+1)'(1)) == total);

  assign rel_req  = rd_evt | fwd_evt;
  assign rel_word = rd_evt ? WORD_W'(make_reply(w, regs[w.idx])) : WORD_W'(hop_down(w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= (i == 0) ? MODE_RST : '0;
    end else if (wr_evt) begin
      regs[w.idx] <= w.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_cnt    <= '0;
      dac_word   <= '0;
      dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= dac_hit;
      if (dac_hit) begin
        dac_word <= in_word;
        dac_cnt  <= '0;
      end else if (dac_evt) begin
        dac_cnt <= dac_cnt + (HOP_W+1)'(1);
      end
    end
  end
endmodule

// File: rtl/ccp_tx.sv
module ccp_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adc_req,
  input  logic [W-1:0] adc_in,
  input  logic         rel_req,
  input  logic [W-1:0] rel_in,
  output logic         busy,
  output logic         sdo,
  output logic         sdo_fs
);
  localparam int CW = $clog2(W + 1);
  logic          adc_pend, rel_pend, g_adc, g_rel;
  logic [W-1:0]  adc_hold, rel_hold, sh;
  logic [CW-1:0] left;

  assign busy  = (left != '0);
  assign g_adc = ~busy & adc_pend;
  assign g_rel = ~busy & ~adc_pend & rel_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_pend <= 1'b0;
      rel_pend <= 1'b0;
      adc_hold <= '0;
      rel_hold <= '0;
    end else begin
      if (g_adc) adc_pend <= 1'b0;
      if (g_rel) rel_pend <= 1'b0;
      if (adc_req) begin
        adc_pend <= 1'b1;
        adc_hold <= adc_in;
      end
      if (rel_req) begin
        rel_pend <= 1'b1;
        rel_hold <= rel_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left   <= '0;
      sh     <= '0;
      sdo    <= 1'b0;
      sdo_fs <= 1'b0;
    end else begin
      sdo_fs <= 1'b0;
      if (g_adc | g_rel) begin
        sdo_fs <= 1'b1;
        sh     <= g_adc ? adc_hold : rel_hold;
        left   <= CW'(W);
      end else if (busy) begin
        sdo  <= sh[W-1];
        sh   <= {sh[W-2:0], 1'b0};
        left <= left - CW'(1);
      end
    end
  end
endmodule

// File: rtl/ccp_top.sv
module ccp_top
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              sdi_fs,
  input  logic              sample_evt,
  input  logic [WORD_W-1:0] adc_word,
  output logic              sdo,
  output logic              sdo_fs,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_strobe
);
  logic              rx_valid;
  logic [WORD_W-1:0] rx_word;
  logic              relay_req;
  logic [WORD_W-1:0] relay_word;
  logic              dac_hit;
  logic              tx_busy;

  ccp_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .fs(sdi_fs),
    .valid(rx_valid), .word(rx_word)
  );

  ccp_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_word(rx_word),
    .rel_req(relay_req), .rel_word(relay_word), .dac_hit(dac_hit),
    .dac_word(dac_word), .dac_strobe(dac_strobe)
  );

  ccp_tx #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .adc_req(sample_evt), .adc_in(adc_word),
    .rel_req(relay_req), .rel_in(relay_word), .busy(tx_busy),
    .sdo(sdo), .sdo_fs(sdo_fs)
  );
endmodule

// File: rtl/ccp_chk.sv
module ccp_chk (
  input logic clk,
  input logic rst_n,
  input logic sdo_fs,
  input logic dac_strobe,
  input logic rx_valid,
  input logic relay_req,
  input logic dac_hit,
  input logic tx_busy
);
  // R1
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_fs |=> !sdo_fs);

  // R1
  fs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_fs |-> $past(!tx_busy));

  // R7
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $past(rx_valid));

  // R3
  relay_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relay_req |-> rx_valid);

  // R7
  dac_not_relayed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_hit |-> !relay_req);
endmodule

bind ccp_top ccp_chk u_chk (.*);

// File: tb/ccp_top_test.sv
module ccp_top_test;
  logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b0, sdi_fs = 1'b0, sample_evt = 1'b0;
  logic [15:0] adc_word = '0;
  logic sdo, sdo_fs, dac_strobe;
  logic [15:0] dac_word;
  int total = 0, bad = 0, strobes = 0;
  logic [15:0] expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  ccp_top uut (.clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
    .sample_evt(sample_evt), .adc_word(adc_word), .sdo(sdo), .sdo_fs(sdo_fs),
    .dac_word(dac_word), .dac_strobe(dac_strobe));

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cw(input bit rd, input logic [2:0] hop, input logic [2:0] idx, input logic [7:0] d);
    return {1'b1, rd, hop, idx, d};
  endfunction
  function automatic logic [15:0] passed(input logic [15:0] w);
    logic [2:0] h;
    h = w[13:11] + 3'd7;
    return {w[15:14], h, w[10:0]};
  endfunction
  function automatic logic [15:0] answer(input logic [2:0] idx, input logic [7:0] v);
    return {2'b11, 3'b111, idx, v};
  endfunction

  // monitor: decode output frames and compare with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && sdo_fs) begin
        logic [15:0] got;
        got = '0;
        for (int i = 0; i < 16; i++) begin
          @(negedge clk);
          got = {got[14:0], sdo};
        end
        if (expq.size() == 0) check(1'b0, "R1 unexpected frame", got, 16'h0);
        else begin
          logic [15:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(got == e, t, got, e);
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && dac_strobe) strobes++;

  task automatic send(input logic [15:0] w, input bit collide, input logic [15:0] aw);
    @(negedge clk);
    sdi_fs = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      sdi_fs = 1'b0;
      sdi = w[i];
    end
    @(negedge clk);
    sdi = 1'b0;
    if (collide) begin
      sample_evt = 1'b1;
      adc_word = aw;
      @(negedge clk);
      sample_evt = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_w(input logic [15:0] w, input string t);
    expq.push_back(w);
    tagq.push_back(t);
  endtask

  task automatic drain();
    repeat (45) @(negedge clk);
    check(expq.size() == 0, "R1 drained", 16'(expq.size()), 16'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int s0;
    do_reset();
    // R12 reset state
    check(sdo_fs == 1'b0, "R12 sdo_fs", 16'(sdo_fs), 16'h0);
    check(dac_word == 16'h0, "R12 dac_word", dac_word, 16'h0);
    check(dac_strobe == 1'b0, "R12 dac_strobe", 16'(dac_strobe), 16'h0);

    // R5 R6 readback of mode register at reset
    expect_w(answer(3'd0, 8'h11), "R6 mode reset readback");
    send(cw(1'b1, 3'd0, 3'd0, 8'h00), 1'b0, '0);
    drain();
    // R3 forward with hop lowered
    expect_w(passed(cw(1'b0, 3'd3, 3'd2, 8'h55)), "R3 forward hop 3");
    send(cw(1'b0, 3'd3, 3'd2, 8'h55), 1'b0, '0);
    drain();
    // R3 a reply from upstream (111b) passes as 110b
    expect_w(answer(3'd4, 8'h9C) - 16'h0800, "R3 reply wraps to 110b");
    send(answer(3'd4, 8'h9C), 1'b0, '0);
    drain();
    // R9 program mode: bit15=0 still a control word
    expect_w(passed(16'h1234), "R9 program mode ctl");
    send(16'h1234, 1'b0, '0);
    drain();
    check(dac_word == 16'h0, "R9 no dac in program mode", dac_word, 16'h0);
    // R4 write then read back
    send(cw(1'b0, 3'd0, 3'd3, 8'hA7), 1'b0, '0);
    drain();
    expect_w(answer(3'd3, 8'hA7), "R4 write readback");
    send(cw(1'b1, 3'd0, 3'd3, 8'h00), 1'b0, '0);
    drain();
    // mixed mode, count 2
    send(cw(1'b0, 3'd0, 3'd0, 8'h32), 1'b0, '0);
    expect_w(answer(3'd0, 8'h32), "R6 mode readback");
    send(cw(1'b1, 3'd0, 3'd0, 8'h00), 1'b0, '0);
    drain();
    // R7 first DAC word does not latch
    s0 = strobes;
    send(16'h0456, 1'b0, '0);
    check(dac_word == 16'h0, "R7 first dac word held", dac_word, 16'h0);
    check(strobes == s0, "R7 no strobe yet", 16'(strobes - s0), 16'h0);
    send(16'h0789, 1'b0, '0);
    check(dac_word == 16'h0789, "R7 second dac word latched", dac_word, 16'h0789);
    check(strobes == s0 + 1, "R7 one strobe", 16'(strobes - s0), 16'h1);
    // R2 bit15=1 forwarded, bit15=0 with hop bits counted not forwarded
    expect_w(passed(cw(1'b0, 3'd1, 3'd5, 8'h3C)), "R2 ctl word forwarded");
    send(cw(1'b0, 3'd1, 3'd5, 8'h3C), 1'b0, '0);
    send(16'h0A5A, 1'b0, '0);
    check(dac_word == 16'h0789, "R2 dac counter restarted", dac_word, 16'h0789);
    send(16'h1111, 1'b0, '0);
    check(dac_word == 16'h1111, "R2 dac word latched", dac_word, 16'h1111);
    drain();
    // R8 count 1
    send(cw(1'b0, 3'd0, 3'd0, 8'h31), 1'b0, '0);
    send(16'h0777, 1'b0, '0);
    check(dac_word == 16'h0777, "R8 immediate latch", dac_word, 16'h0777);
    send(16'h0222, 1'b0, '0);
    check(dac_word == 16'h0222, "R8 immediate latch again", dac_word, 16'h0222);
    // R9 data mode: every word is DAC data
    send(cw(1'b0, 3'd0, 3'd0, 8'h01), 1'b0, '0);
    send(16'h8888, 1'b0, '0);
    check(dac_word == 16'h8888, "R9 data mode dac", dac_word, 16'h8888);
    drain();

    do_reset();
    // R10 sample event
    @(negedge clk);
    sample_evt = 1'b1;
    adc_word = 16'hC3C3;
    @(negedge clk);
    sample_evt = 1'b0;
    adc_word = 16'h0;
    expect_w(16'hC3C3, "R10 adc frame");
    drain();
    // R11 collision: adc first, relay next
    expect_w(16'h5AA5, "R11 adc first");
    expect_w(passed(cw(1'b0, 3'd2, 3'd1, 8'hEE)), "R11 relay second");
    send(cw(1'b0, 3'd2, 3'd1, 8'hEE), 1'b1, 16'h5AA5);
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule